// File: doc/BRIEF.md
# Prioritised Interrupt Vector Controller

This block sits between a set of interrupt flag sources and a CPU. It looks at sixteen fixed vector slots, picks the most urgent one that is pending, raises a request to the CPU and presents both the slot number and the word address the CPU must read the handler pointer from. The vector table sits at the top of the 16-bit address space, two bytes per slot.

Three classes of request exist. The reset slot is driven by a single reset-cause input and ignores every enable. The non-maskable slot is shared by three sources, each gated only by its own enable. The remaining sources are maskable and also need the global enable. When the CPU acknowledges a grant, the block pulses a clear strobe for a source that owns its slot alone. For a maskable grant it also pulses a strobe that tells the owner of the global enable to drop it. Flags that share a slot are left for software to clear.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `irq` is high, `vec_addr` equals 0xFFE0 plus twice `slot`, so slot 0 maps to 0xFFE0 and slot 15 to 0xFFFE.
- R2: When several slots are pending while no grant is held, the highest-numbered slot is granted; `irq` rises one clock after a request appears.
- R3: `reset_req` high requests slot 15 whatever the flags, enables and `gie`; acknowledging slot 15 pulses no clear strobe.
- R4: Flag bits 0 (NMI pin), 1 (oscillator fault) and 2 (flash access violation) request slot 14 when their own enable bit is set, whatever `gie` is.
- R5: Maskable flag bits map to slots as follows: bit 3 comparator to 11, bit 4 watchdog interval to 10, bit 5 timer CCR0 to 9, bit 6 timer shared (CCR1/CCR2/overflow) to 8, bit 7 serial receive to 7, bit 8 serial transmit to 6, bit 9 port 2 to 3, bit 10 port 1 to 2.
- R6: A maskable flag requests only when both its enable bit and `gie` are 1.
- R7: From the rise of `irq` until an acknowledge, `slot` and `vec_addr` stay constant even if higher-priority requests arrive; `irq` is low in the cycle after the acknowledge.
- R8: On an acknowledge while `irq` is high, `flag_clr` pulses the bit of the granted source if it is one of the single-source bits 3, 4, 5, 7, 8; for slots 14, 8, 3 and 2 it stays zero.
- R9: `gie_clr` pulses with an acknowledge of a maskable grant (slots 2 to 11) and stays low for slots 14 and 15.
- R10: `ack` while `irq` is low has no effect: no strobe pulses and the next grant behaves normally.
- R11: Slots 0, 1, 4 and 5 are never granted.
- R12: During and right after reset, `irq` is 0, `slot` is 0 and `vec_addr` is 0xFFE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flag | input | 11 | Per-source pending flags (bit map in R4, R5) |
| src_en | input | 11 | Per-source enables |
| gie | input | 1 | Global enable for maskable sources |
| reset_req | input | 1 | Any reset cause present |
| ack | input | 1 | CPU acknowledge of the current grant |
| irq | output | 1 | Request to the CPU |
| vec_addr | output | 16 | Vector word address of the grant |
| slot | output | 4 | Granted slot number |
| flag_clr | output | 11 | One-cycle clear strobe per source |
| gie_clr | output | 1 | One-cycle strobe to drop the global enable |

## Verification
On every cycle the assertions check that a held grant does not move until acknowledged, that an acknowledge drops the request, that the vector address tracks the slot, that clear strobes are one-hot and only appear with an acknowledge, and that unused slots are never granted. Which source lands in which slot, the enable gating per class, the priority order between mixed requests and which acknowledges clear what can only be shown by the bench's scenarios, since they depend on the fixed source map rather than on any cycle-level invariant.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC       = 11;
  localparam int NSLOT      = 16;
  localparam int SLOT_W     = $clog2(NSLOT);
  localparam int ADDR_W     = 16;
  localparam int RESET_SLOT = NSLOT - 1;
  localparam int NMI_SLOT   = NSLOT - 2;

  // slot each source bit feeds
  function automatic int src_slot(input int i);
    case (i)
      0, 1, 2: src_slot = NMI_SLOT;
      3:       src_slot = 11;
      4:       src_slot = 10;
      5:       src_slot = 9;
      6:       src_slot = 8;
      7:       src_slot = 7;
      8:       src_slot = 6;
      9:       src_slot = 3;
      default: src_slot = 2;
    endcase
  endfunction

  function automatic bit src_nmi(input int i);
    src_nmi = (i <= 2);
  endfunction

  // source owns its slot alone, so the block may clear it on acknowledge
  function automatic bit src_single(input int i);
    src_single = (i == 3) || (i == 4) || (i == 5) || (i == 7) || (i == 8);
  endfunction
endpackage

// File: rtl/irqv_rst_sync.sv
module irqv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqv_src_gate.sv
module irqv_src_gate
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic [NSRC-1:0]  src_flag,
  input  logic [NSRC-1:0]  src_en,
  input  logic             gie,
  input  logic             reset_req,
  output logic [NSLOT-1:0] pend
);
  always_comb begin
    pend = '0;
    pend[RESET_SLOT] = reset_req;
    for (int i = 0; i < NSRC; i++) begin
      if (src_flag[i] && src_en[i] && (src_nmi(i) || gie))
        pend[src_slot(i)] = 1'b1;
    end
  end

  // R6: maskable slots stay quiet without the global enable
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gie |-> (pend[11:2] == '0));
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
  import irqv_pkg::*;
(
  input  logic [NSLOT-1:0]  pend,
  output logic              any,
  output logic [SLOT_W-1:0] win
);
  always_comb begin
    win = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (pend[s]) win = SLOT_W'(s);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_flag,
  input  logic [NSRC-1:0]   src_en,
  input  logic              gie,
  input  logic              reset_req,
  input  logic              ack,
  output logic              irq,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [SLOT_W-1:0] slot,
  output logic [NSRC-1:0]   flag_clr,
  output logic              gie_clr
);
  logic              rst_sync_n;
  logic [NSLOT-1:0]  pend;
  logic              any;
  logic [SLOT_W-1:0] win;

  logic              irq_q, irq_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic              grant_en, take_ack;

  irqv_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irqv_src_gate u_gate (
    .clk(clk), .rst_sync_n(rst_sync_n), .src_flag(src_flag), .src_en(src_en),
    .gie(gie), .reset_req(reset_req), .pend(pend)
  );

  irqv_prio_enc u_enc (.pend(pend), .any(any), .win(win));

  // next state
  assign take_ack = irq_q && ack;
  assign grant_en = !irq_q && any;

  always_comb begin
    irq_d  = irq_q;
    slot_d = slot_q;
    vec_d  = vec_q;
    if (take_ack) begin
      irq_d = 1'b0;
    end else if (grant_en) begin
      irq_d  = 1'b1;
      slot_d = win;
      vec_d  = VEC_BASE + ADDR_W'({win, 1'b0});
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q  <= 1'b0;
      slot_q <= '0;
      vec_q  <= VEC_BASE;
    end else begin
      irq_q <= irq_d;
      if (grant_en) begin
        slot_q <= slot_d;
        vec_q  <= vec_d;
      end
    end
  end

  // acknowledge strobes
  always_comb begin
    flag_clr = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_single(i) && take_ack && (slot_q == SLOT_W'(src_slot(i))))
        flag_clr[i] = 1'b1;
    end
  end

  assign gie_clr  = take_ack && (slot_q < SLOT_W'(NMI_SLOT));
  assign irq      = irq_q;
  assign slot     = slot_q;
  assign vec_addr = vec_q;

  // R7: grant holds until acknowledged
  assert_grant_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_q && !ack) |=> (irq_q && $stable(slot_q) && $stable(vec_q)));
  // R7: acknowledge drops the request
  assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_q && ack) |=> !irq_q);
  // R1: address follows slot
  assert_vec_map_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_q |-> (vec_q == VEC_BASE + ADDR_W'({slot_q, 1'b0})));
  // R2: a new grant needs a pending slot in the cycle before
  assert_rise_pending_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_q) |-> $past(any));
  // R8: clear strobes are one-hot and only with a taken acknowledge
  assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_clr != '0) |-> ($onehot0(flag_clr) && irq_q && ack));
  // R11: unused slots never granted
  assert_unused_slot_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_q |-> !(slot_q == 4'd0 || slot_q == 4'd1 || slot_q == 4'd4 || slot_q == 4'd5));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] src_flag, src_en;
  logic        gie, reset_req, ack;
  logic        irq, gie_clr;
  logic [15:0] vec_addr;
  logic [3:0]  slot;
  logic [10:0] flag_clr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en), .gie(gie),
    .reset_req(reset_req), .ack(ack), .irq(irq), .vec_addr(vec_addr), .slot(slot),
    .flag_clr(flag_clr), .gie_clr(gie_clr)
  );

  // row: flag, en, gie, reset_req, exp_irq, exp_slot, exp_clr, exp_gie_clr
  localparam logic [40:0] TBL [0:12] = '{
    {11'h020, 11'h020, 1'b1, 1'b0, 1'b1, 4'd9,  11'h020, 1'b1}, // R5 CCR0
    {11'h020, 11'h020, 1'b0, 1'b0, 1'b0, 4'd0,  11'h000, 1'b0}, // R6 no gie
    {11'h001, 11'h001, 1'b0, 1'b0, 1'b1, 4'd14, 11'h000, 1'b0}, // R4 nmi pin
    {11'h002, 11'h000, 1'b1, 1'b0, 1'b0, 4'd0,  11'h000, 1'b0}, // R4 osc disabled
    {11'h600, 11'h600, 1'b1, 1'b0, 1'b1, 4'd3,  11'h000, 1'b1}, // R2 port2 over port1
    {11'h048, 11'h048, 1'b1, 1'b0, 1'b1, 4'd11, 11'h008, 1'b1}, // R2 comparator
    {11'h7FF, 11'h7FF, 1'b1, 1'b1, 1'b1, 4'd15, 11'h000, 1'b0}, // R3 reset
    {11'h180, 11'h180, 1'b1, 1'b0, 1'b1, 4'd7,  11'h080, 1'b1}, // R8 rx
    {11'h100, 11'h100, 1'b1, 1'b0, 1'b1, 4'd6,  11'h100, 1'b1}, // R8 tx
    {11'h014, 11'h7FF, 1'b0, 1'b0, 1'b1, 4'd14, 11'h000, 1'b0}, // R4 flash, wdt masked
    {11'h040, 11'h040, 1'b1, 1'b0, 1'b1, 4'd8,  11'h000, 1'b1}, // R8 shared timer
    {11'h7FF, 11'h000, 1'b1, 1'b0, 1'b0, 4'd0,  11'h000, 1'b0}, // R6 no enables
    {11'h400, 11'h400, 1'b1, 1'b0, 1'b1, 4'd2,  11'h000, 1'b1}  // R5 port1
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    src_flag = '0; src_en = '0; gie = 1'b0; reset_req = 1'b0; ack = 1'b0;
  endtask

  task automatic check_grant(input logic [3:0] s, input string req);
    chk(irq == 1'b1, req, irq, 1);
    chk(slot == s, req, slot, s);
    chk(vec_addr == 16'hFFE0 + 16'(s) * 16'd2, {req, " R1"}, vec_addr, 16'hFFE0 + 16'(s) * 16'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R12 irq", irq, 0);
    chk(slot == 4'd0, "R12 slot", slot, 0);
    chk(vec_addr == 16'hFFE0, "R12 vec", vec_addr, 16'hFFE0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq == 1'b0, "R12 irq after release", irq, 0);

    for (int r = 0; r <= 12; r++) begin
      src_flag  = TBL[r][40:30];
      src_en    = TBL[r][29:19];
      gie       = TBL[r][18];
      reset_req = TBL[r][17];
      repeat (2) @(negedge clk);
      if (TBL[r][16]) check_grant(TBL[r][15:12], $sformatf("R2 row%0d", r));
      else chk(irq == 1'b0, $sformatf("R6 row%0d idle", r), irq, 0);
      ack = 1'b1;
      #1;
      chk(flag_clr == TBL[r][11:1], $sformatf("R8 row%0d clr", r), flag_clr, TBL[r][11:1]);
      chk(gie_clr == TBL[r][0], $sformatf("R9 row%0d gie_clr", r), gie_clr, TBL[r][0]);
      @(negedge clk);
      idle_inputs();
      chk(irq == 1'b0, $sformatf("R7 row%0d drop", r), irq, 0);
      repeat (2) @(negedge clk);
    end

    // R7: grant held while a higher slot arrives
    src_flag = 11'h080; src_en = 11'h081; gie = 1'b1;
    repeat (2) @(negedge clk);
    check_grant(4'd7, "R7 first");
    src_flag = 11'h081;
    repeat (3) @(negedge clk);
    check_grant(4'd7, "R7 held");
    ack = 1'b1; #1;
    chk(flag_clr == 11'h080, "R8 held clr", flag_clr, 11'h080);
    @(negedge clk);
    ack = 1'b0; src_flag = 11'h001;
    chk(irq == 1'b0, "R7 gap", irq, 0);
    @(negedge clk);
    check_grant(4'd14, "R7 next nmi");
    ack = 1'b1; #1;
    chk(gie_clr == 1'b0, "R9 nmi no gie_clr", gie_clr, 0);
    chk(flag_clr == 11'h000, "R8 nmi no clr", flag_clr, 0);
    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);

    // R10: stray acknowledge
    ack = 1'b1; #1;
    chk(flag_clr == 11'h000, "R10 stray clr", flag_clr, 0);
    chk(gie_clr == 1'b0, "R10 stray gie_clr", gie_clr, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R10 stray irq", irq, 0);
    ack = 1'b0; src_flag = 11'h010; src_en = 11'h010; gie = 1'b1;
    repeat (2) @(negedge clk);
    check_grant(4'd10, "R10 after stray, R5 wdt");
    ack = 1'b1; #1;
    chk(flag_clr == 11'h010, "R8 wdt clr", flag_clr, 11'h010);
    @(negedge clk);
    idle_inputs();

    // R11: no grant ever points at an unused slot across a sweep
    for (int b = 0; b < 11; b++) begin
      src_flag = 11'(1 << b); src_en = 11'h7FF; gie = 1'b1;
      repeat (2) @(negedge clk);
      chk(irq && !(slot inside {4'd0, 4'd1, 4'd4, 4'd5}), $sformatf("R11 bit%0d", b), slot, 0);
      ack = 1'b1;
      @(negedge clk);
      idle_inputs();
      repeat (2) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule